// File: doc/BRIEF.md
# Receive Lock Source Decision Machine

This block chooses what the receive clock-recovery loop should follow: the incoming serial data, or the local reference clock. It runs in the reference clock domain and combines three inputs. The first is a frequency test: it counts recovered word-clock edges over a fixed window of reference cycles and grades the absolute count difference against thresholds. The thresholds are wider while the loop is locked than while it is unlocked. The second is a run-length test on received parallel words. The third is an active-low pin that pins the loop to the reference.

An upstream sampler reports the number of recovered word-clock rising edges seen in each reference cycle (0, 1 or 2). The received word stream arrives with its own valid strobe. The block outputs a frequency lock state and a select signal that drives an external glitch-free clock multiplexer (1 = data, 0 = reference).

Top module: `rx_lock_src_sel`

## Requirements
- R1: After reset is asserted, `lock_o` is 0 and `sel_data_o` is 0 (reference selected).
- R2: Edges are accumulated over a window of 2^WIN_LOG2 reference cycles, and the count difference is diff = |edges - 2^WIN_LOG2|. `lock_o` changes only at the clock edge that closes a window.
- R3: While unlocked, a window with diff < TH_ACQ_LOCK (default 2) makes the state locked.
- R4: While unlocked, a window with diff in TH_ACQ_LOCK..TH_ACQ_DROP (2..3) is undetermined and holds the unlocked state. A window with diff > TH_ACQ_DROP stays unlocked.
- R5: While locked, a window with diff < TH_HOLD_LOCK (4) keeps the lock. A window with diff in TH_HOLD_LOCK..TH_HOLD_DROP (4..6) is undetermined and also holds the lock.
- R6: While locked, a window with diff > TH_HOLD_DROP (6) makes the state unlocked.
- R7: Loss of signal is raised once RUN_WORDS (12) consecutive valid words are each all ones or each all zeros, all of one polarity. Eleven such words do not raise it. Loss clears `sel_data_o` but leaves `lock_o` unchanged.
- R8: A valid word that is neither all ones nor all zeros resets the run. A uniform word of the opposite polarity restarts the run at one. Cycles without word valid leave the run unchanged. The run count saturates and never wraps.
- R9: `sel_data_o` is 1 only when the state is locked, no loss of signal is present and `force_ref_ni` is high. Driving `force_ref_ni` low clears `sel_data_o` in the same cycle without changing `lock_o`.
- R10: When a window evaluation and a run-length update land on the same clock edge, both take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_edges_i | input | 2 | Recovered word-clock rising edges seen this reference cycle |
| word_valid_i | input | 1 | `word_i` carries a received word this cycle |
| word_i | input | WORD_W | Received parallel word |
| force_ref_ni | input | 1 | Active low: force the loop onto the reference |
| sel_data_o | output | 1 | 1 = track serial data, 0 = track reference |
| lock_o | output | 1 | Frequency lock state |

## Verification
The closing cycle of a frequency window and the arrival of a run-critical word can fall on the same edge, and each changes the select on its own. The bench fills the run to one word short of the limit and then pads to a window boundary. The final uniform word is placed in the last cycle of a window whose edge count is out of range. Both `lock_o` and `sel_data_o` must then fall together. A second window closes with an in-range count and a mixed word in its last cycle. From the unlocked state with loss present, this must raise lock and restore the data selection on the same edge.

// File: rtl/rx_lock_pkg.sv
package rx_lock_pkg;

  typedef enum logic [1:0] {
    BAND_LOCK,
    BAND_HOLD,
    BAND_DROP
  } band_e;

  // Thresholds depend on the current state: lock band, hold band, drop band.
  function automatic band_e classify(input logic locked, input int unsigned diff,
                                     input int unsigned acq_lock, input int unsigned acq_drop,
                                     input int unsigned hold_lock, input int unsigned hold_drop);
    int unsigned lo;
    int unsigned hi;
    lo = locked ? hold_lock : acq_lock;
    hi = locked ? hold_drop : acq_drop;
    if (diff < lo) return BAND_LOCK;
    if (diff <= hi) return BAND_HOLD;
    return BAND_DROP;
  endfunction

endpackage

// File: rtl/rx_lock_freq_meter.sv
module rx_lock_freq_meter #(
  parameter int unsigned WIN_LOG2 = 13,
  localparam int unsigned DW = WIN_LOG2 + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    rec_edges_i,
  output logic          meas_vld_o,
  output logic [DW-1:0] meas_diff_o
);

  localparam logic [DW-1:0] WIN_CNT = {2'b01, {WIN_LOG2{1'b0}}};

  logic [WIN_LOG2-1:0] win_q;
  logic [DW-1:0]       acc_q;
  logic [DW-1:0]       total;

  assign total       = acc_q + DW'(rec_edges_i);
  assign meas_vld_o  = &win_q;
  assign meas_diff_o = (total >= WIN_CNT) ? (total - WIN_CNT) : (WIN_CNT - total);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      acc_q <= '0;
    end else begin
      win_q <= win_q + WIN_LOG2'(1);
      acc_q <= meas_vld_o ? '0 : total;
    end
  end

endmodule

// File: rtl/rx_lock_fsm.sv
module rx_lock_fsm
  import rx_lock_pkg::*;
#(
  parameter int unsigned DW           = 15,
  parameter int unsigned TH_ACQ_LOCK  = 2,
  parameter int unsigned TH_ACQ_DROP  = 3,
  parameter int unsigned TH_HOLD_LOCK = 4,
  parameter int unsigned TH_HOLD_DROP = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          meas_vld_i,
  input  logic [DW-1:0] meas_diff_i,
  output logic          lock_o
);

  logic        lock_q;
  int unsigned diff_u;
  band_e       band;

  assign diff_u = 32'(meas_diff_i);
  assign band   = classify(lock_q, diff_u, TH_ACQ_LOCK, TH_ACQ_DROP, TH_HOLD_LOCK, TH_HOLD_DROP);
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (meas_vld_i) begin
      unique case (band)
        BAND_LOCK: lock_q <= 1'b1;
        BAND_DROP: lock_q <= 1'b0;
        default:   lock_q <= lock_q;  // undetermined keeps the selection
      endcase
    end
  end

endmodule

// File: rtl/rx_lock_run_check.sv
module rx_lock_run_check #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned RUN_WORDS = 12,
  localparam int unsigned CW = $clog2(RUN_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CW-1:0]     run_cnt_o,
  output logic              loss_o
);

  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_WORDS);

  logic [CW-1:0] cnt_q;
  logic          pol_q;
  logic          all_one;
  logic          all_zero;

  assign all_one   = &word_i;
  assign all_zero  = ~|word_i;
  assign run_cnt_o = cnt_q;
  assign loss_o    = (cnt_q == RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (word_valid_i) begin
      if (!(all_one || all_zero)) begin
        cnt_q <= '0;
      end else if (cnt_q != '0 && all_one != pol_q) begin
        cnt_q <= CW'(1);
        pol_q <= all_one;
      end else begin
        pol_q <= all_one;
        if (cnt_q != RUN_MAX) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/rx_lock_src_sel.sv
module rx_lock_src_sel #(
  parameter int unsigned WORD_W       = 10,
  parameter int unsigned WIN_LOG2     = 13,
  parameter int unsigned RUN_WORDS    = 12,
  parameter int unsigned TH_ACQ_LOCK  = 2,
  parameter int unsigned TH_ACQ_DROP  = 3,
  parameter int unsigned TH_HOLD_LOCK = 4,
  parameter int unsigned TH_HOLD_DROP = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rec_edges_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              force_ref_ni,
  output logic              sel_data_o,
  output logic              lock_o
);

  localparam int unsigned DW = WIN_LOG2 + 2;
  localparam int unsigned CW = $clog2(RUN_WORDS + 1);

  logic          meas_vld;
  logic [DW-1:0] meas_diff;
  logic [CW-1:0] run_cnt;
  logic          loss;

  rx_lock_freq_meter #(
    .WIN_LOG2(WIN_LOG2)
  ) i_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rec_edges_i(rec_edges_i),
    .meas_vld_o (meas_vld),
    .meas_diff_o(meas_diff)
  );

  rx_lock_fsm #(
    .DW          (DW),
    .TH_ACQ_LOCK (TH_ACQ_LOCK),
    .TH_ACQ_DROP (TH_ACQ_DROP),
    .TH_HOLD_LOCK(TH_HOLD_LOCK),
    .TH_HOLD_DROP(TH_HOLD_DROP)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_vld_i (meas_vld),
    .meas_diff_i(meas_diff),
    .lock_o     (lock_o)
  );

  rx_lock_run_check #(
    .WORD_W   (WORD_W),
    .RUN_WORDS(RUN_WORDS)
  ) i_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_valid_i(word_valid_i),
    .word_i      (word_i),
    .run_cnt_o   (run_cnt),
    .loss_o      (loss)
  );

  // Mux downstream is glitch-free; force pin acts without a register stage.
  assign sel_data_o = lock_o & ~loss & force_ref_ni;

endmodule

// File: rtl/rx_lock_src_sel_chk.sv
module rx_lock_src_sel_chk #(
  parameter int unsigned WORD_W       = 10,
  parameter int unsigned WIN_LOG2     = 13,
  parameter int unsigned RUN_WORDS    = 12,
  parameter int unsigned TH_ACQ_LOCK  = 2,
  parameter int unsigned TH_HOLD_DROP = 6,
  localparam int unsigned DW = WIN_LOG2 + 2,
  localparam int unsigned CW = $clog2(RUN_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic [WORD_W-1:0] word_i,
  input logic              sel_data_o,
  input logic              lock_o,
  input logic              meas_vld,
  input logic [DW-1:0]     meas_diff,
  input logic [CW-1:0]     run_cnt
);

  localparam logic [DW-1:0] AL = DW'(TH_ACQ_LOCK);
  localparam logic [DW-1:0] HD = DW'(TH_HOLD_DROP);
  localparam logic [CW-1:0] RM = CW'(RUN_WORDS);

  assert_lock_at_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_o) |-> $past(meas_vld));

  assert_acquire_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(meas_vld) && !$past(lock_o) && $past(meas_diff) < AL) |-> lock_o);

  assert_stay_unlocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(meas_vld) && !$past(lock_o) && $past(meas_diff) >= AL) |-> !lock_o);

  assert_hold_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(meas_vld) && $past(lock_o) && $past(meas_diff) <= HD) |-> lock_o);

  assert_drop_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(meas_vld) && $past(lock_o) && $past(meas_diff) > HD) |-> !lock_o);

  assert_loss_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_cnt) == RM && !$past(word_valid_i)) |-> !sel_data_o);

  assert_mixed_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(word_valid_i) && $past(word_i) != '0 && $past(word_i) != '1) |-> run_cnt == '0);

endmodule

bind rx_lock_src_sel rx_lock_src_sel_chk #(
  .WORD_W      (WORD_W),
  .WIN_LOG2    (WIN_LOG2),
  .RUN_WORDS   (RUN_WORDS),
  .TH_ACQ_LOCK (TH_ACQ_LOCK),
  .TH_HOLD_DROP(TH_HOLD_DROP)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_valid_i(word_valid_i),
  .word_i      (word_i),
  .sel_data_o  (sel_data_o),
  .lock_o      (lock_o),
  .meas_vld    (meas_vld),
  .meas_diff   (meas_diff),
  .run_cnt     (run_cnt)
);

// File: tb/test_rx_lock_src_sel.sv
module test_rx_lock_src_sel;

  localparam int WL  = 6;
  localparam int WIN = 1 << WL;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] rec_edges_i = 2'd0;
  logic       word_valid_i = 1'b0;
  logic [9:0] word_i = '0;
  logic       force_ref_ni = 1'b1;
  logic       sel_data_o;
  logic       lock_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk_i = ~clk_i;

  rx_lock_src_sel #(.WORD_W(10), .WIN_LOG2(WL)) i_rx_lock_src_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .rec_edges_i(rec_edges_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .force_ref_ni(force_ref_ni),
    .sel_data_o(sel_data_o), .lock_o(lock_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic [1:0] e, input logic v, input logic [9:0] w);
    rec_edges_i  = e;
    word_valid_i = v;
    word_i       = w;
    @(posedge clk_i);
    #1;
    cyc++;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rec_edges_i = 2'd0; word_valid_i = 1'b0; word_i = '0;
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    cyc = 0;
  endtask

  task automatic window(input int d, input logic lv, input logic [9:0] lw);
    int ad;
    ad = (d < 0) ? -d : d;
    for (int i = 0; i < WIN; i++) begin
      logic [1:0] e;
      e = 2'd1;
      if (i < ad) e = (d > 0) ? 2'd2 : 2'd0;
      tick(e, (i == WIN-1) ? lv : 1'b0, (i == WIN-1) ? lw : 10'h000);
    end
  endtask

  task automatic words(input int n, input logic [9:0] w);
    for (int i = 0; i < n; i++) tick(2'd1, 1'b1, w);
  endtask

  task automatic idle(input int n, input logic [9:0] w);
    for (int i = 0; i < n; i++) tick(2'd1, 1'b0, w);
  endtask

  task automatic pad();
    while (cyc % WIN != 0) tick(2'd1, 1'b0, 10'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 lock after reset", lock_o, 1'b0);
    check("R1 sel after reset", sel_data_o, 1'b0);

    // R2: lock only moves at the window-closing edge
    for (int i = 0; i < WIN-1; i++) tick(2'd1, 1'b0, 10'h000);
    check("R2 mid-window lock", lock_o, 1'b0);
    tick(2'd1, 1'b0, 10'h000);
    check("R2 window close lock", lock_o, 1'b1);
    check("R9 sel when locked", sel_data_o, 1'b1);

    // R1 reset from the locked state
    do_reset();
    check("R1 lock after re-reset", lock_o, 1'b0);

    // sweep from unlocked: R3/R4
    for (int d = -8; d <= 8; d++) begin
      int ad;
      ad = (d < 0) ? -d : d;
      do_reset();
      window(d, 1'b0, 10'h000);
      check((ad < 2) ? "R3 acquire sweep" : "R4 unlocked sweep", lock_o, logic'(ad < 2));
    end

    // sweep from locked: R5/R6
    for (int d = -8; d <= 8; d++) begin
      int ad;
      ad = (d < 0) ? -d : d;
      do_reset();
      window(0, 1'b0, 10'h000);
      window(d, 1'b0, 10'h000);
      check((ad <= 6) ? "R5 locked sweep" : "R6 drop sweep", lock_o, logic'(ad <= 6));
    end

    // hysteresis walk
    do_reset();
    window(0, 1'b0, 10'h000);
    window(5, 1'b0, 10'h000);
    check("R5 hold band keeps lock", lock_o, 1'b1);
    window(7, 1'b0, 10'h000);
    check("R6 drop", lock_o, 1'b0);
    window(3, 1'b0, 10'h000);
    check("R4 hold band keeps unlocked", lock_o, 1'b0);
    window(-2, 1'b0, 10'h000);
    check("R4 lower edge of hold band", lock_o, 1'b0);
    window(-1, 1'b0, 10'h000);
    check("R3 reacquire", lock_o, 1'b1);
    window(-6, 1'b0, 10'h000);
    check("R5 upper edge of hold band", lock_o, 1'b1);

    // run-length (windows stay at d=0)
    words(11, 10'h3FF);
    check("R7 eleven ones no loss", sel_data_o, 1'b1);
    words(1, 10'h3FF);
    check("R7 twelve ones loss", sel_data_o, 1'b0);
    check("R7 lock unaffected", lock_o, 1'b1);
    words(1, 10'h155);
    check("R8 mixed word clears", sel_data_o, 1'b1);
    words(6, 10'h3FF);
    words(6, 10'h000);
    check("R8 polarity flip restarts", sel_data_o, 1'b1);
    words(6, 10'h000);
    check("R8 twelve zeros after flip", sel_data_o, 1'b0);
    words(1, 10'h2A0);
    words(11, 10'h000);
    idle(5, 10'h3FF);
    check("R8 invalid cycles ignored", sel_data_o, 1'b1);
    words(1, 10'h000);
    check("R8 run spans idle gap", sel_data_o, 1'b0);
    words(30, 10'h000);
    check("R8 saturating run", sel_data_o, 1'b0);
    words(1, 10'h3E0);
    check("R8 clear after saturation", sel_data_o, 1'b1);

    // force to reference
    force_ref_ni = 1'b0;
    #1;
    check("R9 force clears sel", sel_data_o, 1'b0);
    check("R9 force keeps lock", lock_o, 1'b1);
    force_ref_ni = 1'b1;
    #1;
    check("R9 release restores sel", sel_data_o, 1'b1);

    // same-edge combination
    pad();
    words(11, 10'h3FF);
    pad();
    window(8, 1'b1, 10'h3FF);
    check("R10 drop and loss lock", lock_o, 1'b0);
    check("R10 drop and loss sel", sel_data_o, 1'b0);
    window(0, 1'b1, 10'h0F0);
    check("R10 acquire and clear lock", lock_o, 1'b1);
    check("R10 acquire and clear sel", sel_data_o, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule